// File: doc/BRIEF.md
# Store Address and Data Formatter

This block sits between store decode and the data-memory port of a 64-bit core. Each cycle it can accept one decoded store. It forms the effective address from a base value and either a sign-extended displacement or a full index value. It then places the stored field into big-endian byte lanes of a doubleword-aligned write, with one byte enable per lane. Update forms also return the effective address for write-back to the base register. That write-back travels alongside the memory request.

The result sits in a single output stage. A full stage blocks new operations until the memory side takes the request. An access that would straddle an 8-byte boundary produces no request and no write-back. Instead it raises a one-cycle misalign flag, so that a trap or split path elsewhere can deal with it.

Top module: `store_fmt`

## Requirements
- R1: For a form without update, `baseIsZero` high makes the base term zero, whatever `baseVal` holds.
- R2: For an update form (`doUpdate` high), the base term is always `baseVal`, even when `baseIsZero` is high.
- R3: With `useIndex` low, the offset is `dispField` sign-extended from 16 to 64 bits. With `useIndex` high, the offset is the full 64-bit `indexVal`. The effective address is base plus offset, modulo 2^64.
- R4: With `useIndex` low and `dsForm` high, bits 1..0 of `dispField` are replaced by zeros before sign extension. The offset is therefore a multiple of 4.
- R5: `sizeCode` 0/1/2/3 selects 1/2/4/8 bytes, taken from the least significant end of `srcVal`. `memAddr` is the effective address with bits 2..0 cleared. Lane k is `memData[63-8k -: 8]`, and `memBe[k]` enables it. Lane number equals the address offset within the doubleword. In normal order the most significant field byte goes to lane EA[2:0] and the following bytes go to higher lanes. All other enables are zero.
- R6: With `byteRev` high, the field's least significant byte goes to lane EA[2:0] and its most significant byte goes to the highest lane used. For a single byte this gives the same result as normal order.
- R7: If EA[2:0] plus the access size exceeds 8, the block raises `misalign` for exactly one cycle, in the cycle after acceptance. No `memValid` and no `wbValid` result from that operation.
- R8: `wbValid` is high exactly when `memValid` is high for an update form. `wbRegId` then carries `baseRegId` and `wbData` carries the full effective address. Forms without update never assert `wbValid`.
- R9: An operation is accepted on a clock edge where `opValid` and `opReady` are both high, with `opReady = !memValid || memReady`. The request appears in the next cycle. While `memValid` is high and `memReady` is low, all request and write-back outputs stay unchanged.
- R10: After reset, `memValid`, `wbValid` and `misalign` are low and `opReady` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Decoded store present |
| opReady | output | 1 | Store can be taken this cycle |
| baseVal | input | 64 | Base register contents |
| indexVal | input | 64 | Index register contents |
| dispField | input | 16 | Raw displacement field |
| baseIsZero | input | 1 | Base specifier names register 0 |
| dsForm | input | 1 | Displacement low two bits are not offset bits |
| useIndex | input | 1 | Offset from index register instead of displacement |
| doUpdate | input | 1 | Update form: write EA back to base |
| byteRev | input | 1 | Byte-reversed lane order |
| sizeCode | input | 2 | Access size: 0=1, 1=2, 2=4, 3=8 bytes |
| srcVal | input | 64 | Source register value |
| baseRegId | input | 5 | Base register number for write-back |
| memValid | output | 1 | Memory write request valid |
| memReady | input | 1 | Memory accepts the request |
| memAddr | output | 64 | Doubleword-aligned address |
| memData | output | 64 | Lane-placed write data |
| memBe | output | 8 | Byte enable per lane |
| misalign | output | 1 | One-cycle pulse: store crossed a doubleword |
| wbValid | output | 1 | Base register write-back valid |
| wbRegId | output | 5 | Base register number |
| wbData | output | 64 | Effective address to write back |

## Verification
The scoreboard targets the cases most easily got wrong. A zero-base flag on an update form must not clear the base; a design that applied the zero rule everywhere would send update stores to offset-only addresses. A DS-form field with low bits set must be truncated; an all-ones field that comes out as -1 instead of -4 shows a missing truncation. Byte-reversed halfword, word and doubleword stores are compared against normal-order ones at several lane offsets, so a lane formatter that mirrors the wrong way, or shifts before reversing, places bytes in the wrong lanes. Stores that straddle a boundary must produce neither a request nor a write-back. Random back-pressure on `memReady` checks that a stalled request never changes and that no operation is lost or duplicated.

// File: rtl/store_fmt_pkg.sv
package store_fmt_pkg;

  typedef struct packed {
    logic capture;   // load the output stage with a good request
    logic flagMis;   // operation accepted but crosses a doubleword
  } fmtStrobe_t;

endpackage

// File: rtl/store_fmt_lanes.sv
module store_fmt_lanes #(
  parameter int DATA_W = 64,
  parameter int LANES  = DATA_W / 8,
  parameter int OFF_W  = $clog2(LANES),
  parameter int SIZE_W = $clog2(OFF_W + 1)
) (
  input  logic [DATA_W-1:0] srcVal,
  input  logic [SIZE_W-1:0] sizeCode,
  input  logic              byteRev,
  input  logic [OFF_W-1:0]  laneOff,
  output logic [DATA_W-1:0] laneData,
  output logic [LANES-1:0]  laneBe,
  output logic              crosses
);

  int nBytes;

  always_comb begin
    nBytes  = 1 << sizeCode;
    crosses = (int'(laneOff) + nBytes) > LANES;
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    int         relIdx;
    int         srcIdx;
    logic       laneHit;
    logic [OFF_W-1:0] srcSel;

    always_comb begin
      relIdx  = k - int'(laneOff);
      laneHit = (relIdx >= 0) && (relIdx < nBytes);
      srcIdx  = byteRev ? relIdx : (nBytes - 1 - relIdx);
      if (!laneHit) srcIdx = 0;
      srcSel  = srcIdx[OFF_W-1:0];
      laneBe[k] = laneHit;
      laneData[DATA_W-1-8*k -: 8] = laneHit ? srcVal[{srcSel, 3'b000} +: 8] : 8'h00;
    end
  end

endmodule

// File: rtl/store_fmt_datapath.sv
module store_fmt_datapath
  import store_fmt_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int DISP_W = 16,
  parameter int REG_W  = 5,
  parameter int LANES  = DATA_W / 8,
  parameter int OFF_W  = $clog2(LANES),
  parameter int SIZE_W = $clog2(OFF_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  fmtStrobe_t        strobe,
  input  logic [DATA_W-1:0] baseVal,
  input  logic [DATA_W-1:0] indexVal,
  input  logic [DISP_W-1:0] dispField,
  input  logic              baseIsZero,
  input  logic              dsForm,
  input  logic              useIndex,
  input  logic              doUpdate,
  input  logic              byteRev,
  input  logic [SIZE_W-1:0] sizeCode,
  input  logic [DATA_W-1:0] srcVal,
  input  logic [REG_W-1:0]  baseRegId,
  output logic              misNow,
  output logic [DATA_W-1:0] memAddr,
  output logic [DATA_W-1:0] memData,
  output logic [LANES-1:0]  memBe,
  output logic [REG_W-1:0]  wbRegId,
  output logic [DATA_W-1:0] wbData
);

  localparam int EXT_W = DATA_W - DISP_W;

  logic [DISP_W-1:0] dispEff;
  logic [DATA_W-1:0] baseTerm;
  logic [DATA_W-1:0] offTerm;
  logic [DATA_W-1:0] effAddr;
  logic [DATA_W-1:0] laneData;
  logic [LANES-1:0]  laneBe;

  always_comb begin
    dispEff  = dsForm ? {dispField[DISP_W-1:2], 2'b00} : dispField;
    baseTerm = (baseIsZero && !doUpdate) ? '0 : baseVal;
    offTerm  = useIndex ? indexVal : {{EXT_W{dispEff[DISP_W-1]}}, dispEff};
    effAddr  = baseTerm + offTerm;
  end

  store_fmt_lanes #(
    .DATA_W(DATA_W), .LANES(LANES), .OFF_W(OFF_W), .SIZE_W(SIZE_W)
  ) u_lanes (
    .srcVal  (srcVal),
    .sizeCode(sizeCode),
    .byteRev (byteRev),
    .laneOff (effAddr[OFF_W-1:0]),
    .laneData(laneData),
    .laneBe  (laneBe),
    .crosses (misNow)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memAddr <= '0;
      memData <= '0;
      memBe   <= '0;
      wbRegId <= '0;
      wbData  <= '0;
    end else if (strobe.capture) begin
      memAddr <= {effAddr[DATA_W-1:OFF_W], {OFF_W{1'b0}}};
      memData <= laneData;
      memBe   <= laneBe;
      wbRegId <= baseRegId;
      wbData  <= effAddr;
    end
  end

  AST_BE_SIZE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> ($countones(memBe) == 1 || $countones(memBe) == 2 ||
                        $countones(memBe) == 4 || $countones(memBe) == 8)); // R5

  AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> ($stable(memData) && $stable(memBe) && $stable(wbData))); // R9

  AST_NO_CAPTURE_ON_CROSS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |-> !misNow); // R7

endmodule

// File: rtl/store_fmt_ctrl.sv
module store_fmt_ctrl
  import store_fmt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       opValid,
  input  logic       doUpdate,
  input  logic       misNow,
  input  logic       memReady,
  output logic       opReady,
  output logic       memValid,
  output logic       wbValid,
  output logic       misalign,
  output fmtStrobe_t strobe
);

  logic stageFull;
  logic updQ;
  logic accept;

  always_comb begin
    opReady        = !stageFull || memReady;
    accept         = opValid && opReady;
    strobe.capture = accept && !misNow;
    strobe.flagMis = accept && misNow;
    memValid       = stageFull;
    wbValid        = stageFull && updQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stageFull <= 1'b0;
      updQ      <= 1'b0;
      misalign  <= 1'b0;
    end else begin
      misalign <= strobe.flagMis;
      if (strobe.capture) begin
        stageFull <= 1'b1;
        updQ      <= doUpdate;
      end else if (memReady) begin
        stageFull <= 1'b0;
        updQ      <= 1'b0;
      end
    end
  end

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memReady) |=> memValid); // R9

  AST_WB_WITH_REQ: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |-> memValid); // R8

  AST_MIS_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    misalign |-> (!memValid && !wbValid)); // R7

  AST_MIS_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(misalign) |-> $past(opValid && opReady)); // R7

endmodule

// File: rtl/store_fmt.sv
module store_fmt
  import store_fmt_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int DISP_W = 16,
  parameter int REG_W  = 5,
  parameter int LANES  = DATA_W / 8,
  parameter int OFF_W  = $clog2(LANES),
  parameter int SIZE_W = $clog2(OFF_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  output logic              opReady,
  input  logic [DATA_W-1:0] baseVal,
  input  logic [DATA_W-1:0] indexVal,
  input  logic [DISP_W-1:0] dispField,
  input  logic              baseIsZero,
  input  logic              dsForm,
  input  logic              useIndex,
  input  logic              doUpdate,
  input  logic              byteRev,
  input  logic [SIZE_W-1:0] sizeCode,
  input  logic [DATA_W-1:0] srcVal,
  input  logic [REG_W-1:0]  baseRegId,
  output logic              memValid,
  input  logic              memReady,
  output logic [DATA_W-1:0] memAddr,
  output logic [DATA_W-1:0] memData,
  output logic [LANES-1:0]  memBe,
  output logic              misalign,
  output logic              wbValid,
  output logic [REG_W-1:0]  wbRegId,
  output logic [DATA_W-1:0] wbData
);

  fmtStrobe_t strobe;
  logic       misNow;

  store_fmt_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .opValid (opValid),
    .doUpdate(doUpdate),
    .misNow  (misNow),
    .memReady(memReady),
    .opReady (opReady),
    .memValid(memValid),
    .wbValid (wbValid),
    .misalign(misalign),
    .strobe  (strobe)
  );

  store_fmt_datapath #(
    .DATA_W(DATA_W), .DISP_W(DISP_W), .REG_W(REG_W),
    .LANES(LANES), .OFF_W(OFF_W), .SIZE_W(SIZE_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .baseVal   (baseVal),
    .indexVal  (indexVal),
    .dispField (dispField),
    .baseIsZero(baseIsZero),
    .dsForm    (dsForm),
    .useIndex  (useIndex),
    .doUpdate  (doUpdate),
    .byteRev   (byteRev),
    .sizeCode  (sizeCode),
    .srcVal    (srcVal),
    .baseRegId (baseRegId),
    .misNow    (misNow),
    .memAddr   (memAddr),
    .memData   (memData),
    .memBe     (memBe),
    .wbRegId   (wbRegId),
    .wbData    (wbData)
  );

endmodule

// File: tb/store_fmt_test.sv
module store_fmt_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic        opReady;
  logic [63:0] baseVal = '0, indexVal = '0, srcVal = '0;
  logic [15:0] dispField = '0;
  logic        baseIsZero = 1'b0, dsForm = 1'b0, useIndex = 1'b0;
  logic        doUpdate = 1'b0, byteRev = 1'b0;
  logic [1:0]  sizeCode = '0;
  logic [4:0]  baseRegId = '0;
  logic        memValid, memReady = 1'b1, misalign, wbValid;
  logic [63:0] memAddr, memData, wbData;
  logic [7:0]  memBe;
  logic [4:0]  wbRegId;

  typedef struct {
    bit          isMis;
    logic [63:0] addr;
    logic [63:0] data;
    logic [7:0]  be;
    bit          wb;
    logic [4:0]  wbReg;
    logic [63:0] wbVal;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];
  int  nChecks = 0;
  int  nFails = 0;
  bit  finished = 1'b0;
  bit  randReady = 1'b0;

  always #5 clk = ~clk;

  store_fmt uut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opReady(opReady),
    .baseVal(baseVal), .indexVal(indexVal), .dispField(dispField),
    .baseIsZero(baseIsZero), .dsForm(dsForm), .useIndex(useIndex),
    .doUpdate(doUpdate), .byteRev(byteRev), .sizeCode(sizeCode),
    .srcVal(srcVal), .baseRegId(baseRegId), .memValid(memValid),
    .memReady(memReady), .memAddr(memAddr), .memData(memData),
    .memBe(memBe), .misalign(misalign), .wbValid(wbValid),
    .wbRegId(wbRegId), .wbData(wbData)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Reference model built from the requirement text.
  function automatic expItem_t model(input logic [63:0] b, input logic [63:0] x,
      input logic [15:0] d, input bit bz, input bit ds, input bit ix, input bit up,
      input bit rv, input logic [1:0] sz, input logic [63:0] s, input logic [4:0] rid);
    expItem_t e;
    logic [63:0] base, off, ea;
    logic [15:0] dd;
    logic [7:0]  fb [8];
    int n, o;
    base = (bz && !up) ? 64'd0 : b;                       // R1 R2
    dd   = ds ? (d & 16'hFFFC) : d;                       // R4
    off  = ix ? x : {{48{dd[15]}}, dd};                   // R3
    ea   = base + off;
    n    = 1 << sz;
    o    = int'(ea[2:0]);
    e.isMis = (o + n) > 8;                                // R7
    e.addr  = ea & ~64'h7;
    e.data  = '0;
    e.be    = '0;
    for (int j = 0; j < n; j++) begin                     // R5 R6
      if (rv) fb[j] = s[8*j +: 8];
      else    fb[j] = s[8*(n-1-j) +: 8];
    end
    if (!e.isMis) begin
      for (int j = 0; j < n; j++) begin
        e.be[o+j] = 1'b1;
        e.data[63-8*(o+j) -: 8] = fb[j];
      end
    end
    e.wb    = up;
    e.wbReg = rid;
    e.wbVal = ea;
    return e;
  endfunction

  task automatic drive(input logic [63:0] b, input logic [63:0] x, input logic [15:0] d,
      input bit bz, input bit ds, input bit ix, input bit up, input bit rv,
      input logic [1:0] sz, input logic [63:0] s, input logic [4:0] rid, input string tag);
    expItem_t e;
    @(negedge clk);
    baseVal = b; indexVal = x; dispField = d; baseIsZero = bz; dsForm = ds;
    useIndex = ix; doUpdate = up; byteRev = rv; sizeCode = sz; srcVal = s;
    baseRegId = rid; opValid = 1'b1;
    #1;
    while (!opReady) begin
      @(negedge clk);
      #1;
    end
    e = model(b, x, d, bz, ds, ix, up, rv, sz, s, rid);
    e.tag = tag;
    expQ.push_back(e);
    @(posedge clk);
  endtask

  // Back-pressure generator: changes just after the edge.
  always @(posedge clk) begin
    #1;
    memReady = randReady ? ($urandom_range(0, 2) != 0) : 1'b1;
  end

  // Monitor / scoreboard.
  logic        prevValid = 1'b0, prevReady = 1'b0;
  logic [63:0] prevAddr, prevData, prevWb;
  logic [7:0]  prevBe;
  logic        prevWbv;

  always @(negedge clk) begin
    expItem_t e;
    if (rstN && !finished) begin
      if (memValid && prevValid && !prevReady) begin
        check(memAddr == prevAddr && memData == prevData && memBe == prevBe &&
              wbValid == prevWbv && wbData == prevWb, "R9 held request", memData, prevData);
      end
      if (misalign) begin
        if (expQ.size() == 0) check(1'b0, "R7 unexpected misalign", 64'd1, 64'd0);
        else begin
          e = expQ.pop_front();
          check(e.isMis, {"R7 misalign raised ", e.tag}, 64'd1, {63'd0, e.isMis});
          check(!memValid && !wbValid, "R7 no request with misalign", {62'd0, memValid, wbValid}, 64'd0);
        end
      end
      if (memValid && memReady) begin
        if (expQ.size() == 0) check(1'b0, "R9 unexpected request", memAddr, 64'd0);
        else begin
          e = expQ.pop_front();
          check(!e.isMis, {"R7 request for crossing store ", e.tag}, 64'd1, 64'd0);
          check(memAddr == e.addr, {"R3 address ", e.tag}, memAddr, e.addr);
          check(memData == e.data, {"R5 R6 data ", e.tag}, memData, e.data);
          check(memBe == e.be, {"R5 byte enables ", e.tag}, {56'd0, memBe}, {56'd0, e.be});
          check(wbValid == e.wb, {"R8 write-back valid ", e.tag}, {63'd0, wbValid}, {63'd0, e.wb});
          if (e.wb) begin
            check(wbData == e.wbVal && wbRegId == e.wbReg, {"R8 R2 write-back ", e.tag},
                  wbData, e.wbVal);
          end
        end
      end
      prevValid = memValid; prevReady = memReady;
      prevAddr = memAddr; prevData = memData; prevBe = memBe;
      prevWb = wbData; prevWbv = wbValid;
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual %0d expected %0d", 100000, 0);
    finish_run();
  end

  localparam logic [63:0] SRC = 64'h0123_4567_89AB_CDEF;

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    check(!memValid && !wbValid && !misalign && opReady, "R10 reset state",
          {60'd0, memValid, wbValid, misalign, opReady}, 64'd1);

    // R5 byte, normal order, lane 5
    drive(64'h1000, 0, 16'd5, 0, 0, 0, 0, 0, 2'd0, SRC, 5'd3, "R5 byte");
    // R5 halfword at offset 2
    drive(64'h2000, 0, 16'd2, 0, 0, 0, 0, 0, 2'd1, SRC, 5'd3, "R5 half");
    // R6 byte-reversed word at offset 4
    drive(64'h3000, 0, 16'd4, 0, 0, 0, 0, 1, 2'd2, SRC, 5'd3, "R6 word rev");
    // R6 byte-reversed doubleword
    drive(64'h4000, 0, 16'd0, 0, 0, 1, 0, 1, 2'd3, SRC, 5'd3, "R6 dword rev");
    // R6 byte-reversed single byte equals normal
    drive(64'h4000, 0, 16'd7, 0, 0, 0, 0, 1, 2'd0, SRC, 5'd3, "R6 byte rev");
    // R1 zero base on non-update form
    drive(64'hDEAD_0000, 0, 16'h0010, 1, 0, 0, 0, 0, 2'd3, SRC, 5'd0, "R1 zero base");
    // R2 update form ignores the zero flag and writes back
    drive(64'h5000, 0, 16'h0008, 1, 0, 0, 1, 0, 2'd2, SRC, 5'd9, "R2 update");
    // R3 negative displacement
    drive(64'h6000, 0, 16'hFFF8, 0, 0, 0, 0, 0, 2'd3, SRC, 5'd1, "R3 neg disp");
    // R3 indexed with full-width index
    drive(64'h10, 64'h8000_0000_0000_0000, 16'h7FFF, 0, 0, 1, 1, 0, 2'd1, SRC, 5'd30, "R3 index");
    // R4 DS form: all-ones field means -4
    drive(64'h7008, 0, 16'hFFFF, 0, 1, 0, 1, 0, 2'd2, SRC, 5'd4, "R4 ds");
    // R7 word crossing at offset 6
    drive(64'h8006, 0, 16'd0, 0, 0, 0, 0, 0, 2'd2, SRC, 5'd2, "R7 word cross");
    // R7 update doubleword crossing: no write-back
    drive(64'h9001, 0, 16'd0, 0, 0, 0, 1, 0, 2'd3, SRC, 5'd2, "R7 dword cross");
    // R8 non-update follows an update
    drive(64'hA000, 0, 16'd4, 0, 0, 0, 0, 0, 2'd2, SRC, 5'd7, "R8 no wb");

    randReady = 1'b1;
    for (int i = 0; i < 400; i++) begin
      drive({$urandom, $urandom}, {$urandom, $urandom}, 16'($urandom),
            1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
            2'($urandom), {$urandom, $urandom}, 5'($urandom), "R9 random");
    end
    @(negedge clk);
    opValid = 1'b0;
    randReady = 1'b0;
    repeat (10) @(posedge clk);
    check(expQ.size() == 0, "R9 all operations delivered", 64'(expQ.size()), 64'd0);
    finish_run();
  end

endmodule